// File: doc/BRIEF.md
# CAN Error State Monitor

This block turns the two error counters of a CAN controller into two 2-bit bus status codes, one for the transmitter and one for the receiver. The error counting itself is done elsewhere; the 9-bit transmit count and the 8-bit receive count arrive as inputs. Each counter is compared against fixed limits. When the transmitter goes bus-off, the receiver code also reports bus-off. When the transmitter leaves bus-off, the receiver code drops straight to OK.

Any change in either code is latched into the reported codes and raises a sticky status change flag. While the flag is set, the reported codes stay frozen. This lets the host read a consistent pair, then clear the flag by writing a one to it. The interrupt line is the flag gated by an enable bit. That enable is forced low during initialization mode, and host writes to it are accepted only when the controller is fully out of initialization.

Top module: `can_err_state_mon`

## Requirements
- R1: The transmitter code is 00 for a transmit count of 0..96, 01 for 97..127, 10 for 128..255 and 11 for 256 and above.
- R2: When the transmitter is not bus-off and has not just left bus-off, the receiver code is 00 for a receive count of 0..96, 01 for 97..127 and 10 for 128 and above.
- R3: While the reported transmitter code is 11, the reported receiver code is also 11.
- R4: On the update where the transmitter code leaves 11, the receiver code becomes 00, whatever the receive count is.
- R5: With the flag clear, a count change that alters either code updates both codes and sets the flag at the next rising clock edge.
- R6: While the flag is set, both reported codes hold, whatever the counters do.
- R7: Asserting flag_clr_i while the flag is set clears it at the next edge. The codes stay held on that edge and resume tracking on the edge after.
- R8: irq_o is high exactly when the flag and the enable bit are both high.
- R9: While init_req_i and init_ack_i are both high, the enable bit is forced to 0 at every edge.
- R10: A write (ie_we_i with the value on ie_wdata_i) loads the enable bit only when init_req_i and init_ack_i are both low. In any other combination the write is ignored and the enable keeps its value.
- R11: After reset, both codes are 00, the flag is 0, the enable is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_cnt_i | input | 9 | Transmit error count |
| rx_err_cnt_i | input | 8 | Receive error count |
| init_req_i | input | 1 | Initialization mode request |
| init_ack_i | input | 1 | Initialization mode acknowledge |
| ie_we_i | input | 1 | Write strobe for the enable bit |
| ie_wdata_i | input | 1 | Value written to the enable bit |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| tx_state_o | output | 2 | Reported transmitter code |
| rx_state_o | output | 2 | Reported receiver code |
| chg_flag_o | output | 1 | Status change flag |
| chg_ie_o | output | 1 | Status change interrupt enable |
| irq_o | output | 1 | Status change interrupt |

## Verification
A wrong code register shows up on tx_state_o or rx_state_o one edge after the counter move that should have changed it. A missed update also leaves chg_flag_o low at that same edge. A flag that fails to freeze the codes lets them drift within one cycle of a counter change. A stuck flag holds the codes past the cycle after the clear. An enable that ignores the initialization inputs becomes visible on chg_ie_o and irq_o at the very next edge. The bench compares every output on every cycle against a model. This catches each of these faults within one clock.

// File: rtl/can_esm_pkg.sv
package can_esm_pkg;
  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_WARN = 2'b01,
    ST_ERR  = 2'b10,
    ST_OFF  = 2'b11
  } bus_st_e;

  localparam int TX_CNT_W = 9;
  localparam int RX_CNT_W = 8;
  localparam int WARN_LIM = 96;
  localparam int ERR_LIM  = 127;
  localparam int OFF_LIM  = 255;
endpackage

// File: rtl/can_esm_classify.sv
module can_esm_classify
  import can_esm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int WARN    = WARN_LIM,
  parameter int ERR     = ERR_LIM,
  parameter int OFF     = OFF_LIM,
  parameter bit HAS_OFF = 1'b0
) (
  input  logic [CNT_W-1:0] cnt_i,
  output bus_st_e          st_o
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic above_warn, above_err, above_off;

  assign above_warn = int'(cnt_i) > WARN;
  assign above_err  = int'(cnt_i) > ERR;

  generate
    if (HAS_OFF && (OFF < CNT_MAX)) begin : g_off
      assign above_off = int'(cnt_i) > OFF;
    end else begin : g_no_off
      assign above_off = 1'b0;
    end
  endgenerate

  always_comb begin
    if (above_off)       st_o = ST_OFF;
    else if (above_err)  st_o = ST_ERR;
    else if (above_warn) st_o = ST_WARN;
    else                 st_o = ST_OK;
  end
endmodule

// File: rtl/can_esm_latch.sv
module can_esm_latch
  import can_esm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bus_st_e tx_raw_i,
  input  bus_st_e rx_raw_i,
  input  logic    clr_i,
  output bus_st_e tx_o,
  output bus_st_e rx_o,
  output logic    flag_o
);
  bus_st_e tx_q, rx_q, rx_nxt;
  logic    flag_q, diff;

  // receiver mirrors bus-off; snaps to OK on exit
  always_comb begin
    if (tx_raw_i == ST_OFF)  rx_nxt = ST_OFF;
    else if (tx_q == ST_OFF) rx_nxt = ST_OK;
    else                     rx_nxt = rx_raw_i;
    diff = (tx_raw_i != tx_q) || (rx_nxt != rx_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= ST_OK;
      rx_q   <= ST_OK;
      flag_q <= 1'b0;
    end else if (flag_q) begin
      if (clr_i) flag_q <= 1'b0;
    end else if (diff) begin
      tx_q   <= tx_raw_i;
      rx_q   <= rx_nxt;
      flag_q <= 1'b1;
    end
  end

  assign tx_o   = tx_q;
  assign rx_o   = rx_q;
  assign flag_o = flag_q;

  // R3
  rx_mirrors_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_q == ST_OFF) |-> (rx_q == ST_OFF));

  // R4
  rx_snap_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_q != ST_OFF) && ($past(tx_q) == ST_OFF)) |-> (rx_q == ST_OK));

  // R5
  change_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tx_q) || !$stable(rx_q)) |-> flag_q);

  // R6
  codes_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> ($stable(tx_q) && $stable(rx_q) && flag_q));

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && clr_i) |=> (!flag_q && $stable(tx_q) && $stable(rx_q)));
endmodule

// File: rtl/can_esm_ie.sv
module can_esm_ie (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_req_i,
  input  logic init_ack_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic ie_o
);
  logic ie_q, in_init, wr_ok;

  assign in_init = init_req_i & init_ack_i;
  assign wr_ok   = we_i & ~init_req_i & ~init_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (in_init) ie_q <= 1'b0;
    else if (wr_ok)   ie_q <= wdata_i;
  end

  assign ie_o = ie_q;

  // R9
  ie_init_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_req_i && init_ack_i) |=> !ie_q);

  // R10
  ie_wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(init_req_i && init_ack_i) && !(we_i && !init_req_i && !init_ack_i)) |=> $stable(ie_q));
endmodule

// File: rtl/can_err_state_mon.sv
module can_err_state_mon
  import can_esm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TX_CNT_W-1:0] tx_err_cnt_i,
  input  logic [RX_CNT_W-1:0] rx_err_cnt_i,
  input  logic                init_req_i,
  input  logic                init_ack_i,
  input  logic                ie_we_i,
  input  logic                ie_wdata_i,
  input  logic                flag_clr_i,
  output logic [1:0]          tx_state_o,
  output logic [1:0]          rx_state_o,
  output logic                chg_flag_o,
  output logic                chg_ie_o,
  output logic                irq_o
);
  bus_st_e tx_raw, rx_raw, tx_st, rx_st;
  logic    flag, ie;

  can_esm_classify #(.CNT_W(TX_CNT_W), .HAS_OFF(1'b1)) u_tx_cls (
    .cnt_i(tx_err_cnt_i), .st_o(tx_raw));

  can_esm_classify #(.CNT_W(RX_CNT_W), .HAS_OFF(1'b0)) u_rx_cls (
    .cnt_i(rx_err_cnt_i), .st_o(rx_raw));

  can_esm_latch u_latch (
    .clk_i, .rst_ni,
    .tx_raw_i(tx_raw), .rx_raw_i(rx_raw), .clr_i(flag_clr_i),
    .tx_o(tx_st), .rx_o(rx_st), .flag_o(flag));

  can_esm_ie u_ie (
    .clk_i, .rst_ni,
    .init_req_i, .init_ack_i,
    .we_i(ie_we_i), .wdata_i(ie_wdata_i), .ie_o(ie));

  assign tx_state_o = tx_st;
  assign rx_state_o = rx_st;
  assign chg_flag_o = flag;
  assign chg_ie_o   = ie;
  assign irq_o      = flag & ie;

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg_flag_o && chg_ie_o));

  // R11
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (tx_state_o == 2'b00 && rx_state_o == 2'b00 && !chg_flag_o && !irq_o));
endmodule

// File: tb/can_err_state_mon_tb_top.sv
module can_err_state_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tx_cnt = '0;
  logic [7:0] rx_cnt = '0;
  logic       req = 1'b0, ack = 1'b0, we = 1'b0, wd = 1'b0, clr = 1'b0;
  logic [1:0] tx_st, rx_st;
  logic       flag, ie, irq;

  int checks = 0, fails = 0;
  logic [1:0] m_tx = 2'b00, m_rx = 2'b00;
  logic       m_flag = 1'b0, m_ie = 1'b0;

  always #4 clk = ~clk;

  can_err_state_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_err_cnt_i(tx_cnt), .rx_err_cnt_i(rx_cnt),
    .init_req_i(req), .init_ack_i(ack),
    .ie_we_i(we), .ie_wdata_i(wd), .flag_clr_i(clr),
    .tx_state_o(tx_st), .rx_state_o(rx_st),
    .chg_flag_o(flag), .chg_ie_o(ie), .irq_o(irq));

  function automatic logic [1:0] tx_code(input int c);
    if (c > 255) return 2'b11;
    if (c > 127) return 2'b10;
    if (c > 96)  return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [1:0] rx_code(input int c);
    if (c > 127) return 2'b10;
    if (c > 96)  return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req_tag, act, exp, $time);
    end
  endtask

  // advance one edge, update the model, compare all outputs
  task automatic step();
    logic [1:0] t, r;
    @(posedge clk);
    if (req && ack) m_ie = 1'b0;
    else if (we && !req && !ack) m_ie = wd;
    if (m_flag) begin
      if (clr) m_flag = 1'b0;
    end else begin
      t = tx_code(int'(tx_cnt));
      if (t == 2'b11)       r = 2'b11;
      else if (m_tx == 2'b11) r = 2'b00;
      else                  r = rx_code(int'(rx_cnt));
      if (t != m_tx || r != m_rx) begin
        m_tx = t; m_rx = r; m_flag = 1'b1;
      end
    end
    #2;
    chk("R1 tx code", tx_st, m_tx);
    chk("R2 rx code", rx_st, m_rx);
    chk("R5 flag", flag, m_flag);
    chk("R9/R10 enable", ie, m_ie);
    chk("R8 irq", irq, m_flag & m_ie);
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  function automatic logic [8:0] pick_tx();
    int sel = $urandom_range(0, 11);
    case (sel)
      0: return 9'd96;  1: return 9'd97;  2: return 9'd127; 3: return 9'd128;
      4: return 9'd255; 5: return 9'd256; 6: return 9'd0;   7: return 9'd511;
      default: return 9'($urandom_range(0, 511));
    endcase
  endfunction

  function automatic logic [7:0] pick_rx();
    int sel = $urandom_range(0, 8);
    case (sel)
      0: return 8'd96; 1: return 8'd97; 2: return 8'd127; 3: return 8'd128;
      4: return 8'd255; 5: return 8'd0;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #10;
    // R11 reset state
    chk("R11 tx reset", tx_st, 0);
    chk("R11 rx reset", rx_st, 0);
    chk("R11 flag reset", flag, 0);
    chk("R11 ie reset", ie, 0);
    chk("R11 irq reset", irq, 0);
    @(negedge clk); rst_n = 1'b1;

    // R10 enable write out of init
    we = 1; wd = 1; step(); we = 0;
    chk("R10 ie written", ie, 1);

    // R1 warning boundary, R5 flag
    tx_cnt = 9'd96; step();
    chk("R1 tx at 96", tx_st, 0);
    chk("R5 no flag at 96", flag, 0);
    tx_cnt = 9'd97; step();
    chk("R1 tx at 97", tx_st, 1);
    chk("R5 flag set", flag, 1);
    chk("R8 irq on", irq, 1);

    // R6 hold while flag set
    tx_cnt = 9'd200; rx_cnt = 8'd130; step(); step();
    chk("R6 tx held", tx_st, 1);
    chk("R6 rx held", rx_st, 0);

    // R7 clear; codes resume next edge
    clear_flag();
    chk("R7 flag cleared", flag, 0);
    chk("R7 tx still held", tx_st, 1);
    step();
    chk("R7 tx resumed", tx_st, 2);
    chk("R2 rx above 127", rx_st, 2);
    clear_flag();

    // R3 bus-off mirror
    tx_cnt = 9'd256; rx_cnt = 8'd20; step();
    chk("R3 tx bus-off", tx_st, 3);
    chk("R3 rx mirrors", rx_st, 3);
    clear_flag();

    // R4 snap to OK on exit
    tx_cnt = 9'd0; rx_cnt = 8'd120; step();
    chk("R4 tx left bus-off", tx_st, 0);
    chk("R4 rx snapped", rx_st, 0);
    clear_flag(); step();
    chk("R2 rx tracks after snap", rx_st, 1);
    clear_flag();

    // R9 init forces enable low; R10 write ignored in init
    req = 1; ack = 1; we = 1; wd = 1; step();
    chk("R9 ie low in init", ie, 0);
    ack = 0; step();
    chk("R10 write ignored req only", ie, 0);
    req = 0; ack = 1; step();
    chk("R10 write ignored ack only", ie, 0);
    ack = 0; step(); we = 0;
    chk("R10 write accepted", ie, 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) tx_cnt = pick_tx();
      if ($urandom_range(0, 3) == 0) rx_cnt = pick_rx();
      clr = ($urandom_range(0, 3) == 0);
      we  = ($urandom_range(0, 7) == 0);
      wd  = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin
        req = 1'($urandom_range(0, 1));
        ack = 1'($urandom_range(0, 1));
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule